// File: doc/BRIEF.md
# Asynchronous Handshake to Synchronous Acknowledge Bridge

This block sits between a processor whose bus is clocked and a slower peripheral that answers with a strobe-and-acknowledge handshake that has no clock. A transfer begins when the processor raises a one-cycle start pulse while the address decoder's select is high. The bridge then lowers the peripheral's address strobe and chip select, and lowers the data strobe one clock later. It then waits for the peripheral to pull low one or both of its two acknowledge lines.

Both acknowledge lines pass through a two-flop synchronizer. On the first clock where either synchronized line is active, the bridge gives the processor a single-clock transfer-done pulse. It latches which lines answered as a port-size code and releases all strobes. If no answer comes within a programmable number of clocks, the bridge ends the cycle with a single-clock transfer-error pulse instead. After either ending, it refuses new starts until both acknowledge lines are seen inactive again. This keeps the last answer from leaking into the next cycle.

Top module: `hs_ack_bridge`

## Requirements
- R1: While reset is held low at a clock edge, and after it, the three strobes are high (inactive), the done and error pulses are low and the port-size code is 00.
- R2: A start pulse with select high, sampled at a clock edge while idle, drives address strobe and chip select low after that edge. The data strobe goes low after the next edge, with address strobe still low.
- R3: A start pulse sampled with select low has no effect: all strobes stay high.
- R4: If an acknowledge line goes low while the data strobe is low, the done pulse appears after the third rising clock edge that follows the change.
- R5: The done pulse and the error pulse each last exactly one clock, are never high together, and all three strobes are high in that same clock.
- R6: The port-size code latched with the done pulse uses two bits. Bit 1 means the wide line (acknowledge bit 1) was low and bit 0 means the narrow line (acknowledge bit 0) was low. So 01 means 8-bit, 10 means 16-bit and 11 means 32-bit. The code is 00 after a timeout, and it holds until the next cycle ends.
- R7: After a cycle ends, a start is ignored until both acknowledge lines have been inactive through the synchronizer. A start sampled at the third edge after the lines rise is still ignored; one sampled at the fourth edge is accepted.
- R8: With a nonzero limit N and no acknowledge, the error pulse appears after the N-th rising edge counted from the edge that lowered the data strobe, and no done pulse is given.
- R9: A limit of zero disables the timeout, so the bridge waits for an acknowledge without bound.
- R10: If an acknowledge is seen on the same edge at which the timeout expires, the cycle ends with done, not with error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | One-cycle transfer-start pulse from the processor |
| xfer_sel | input | 1 | Decoded select for this peripheral, sampled with the start pulse |
| wait_limit | input | TMO_W | Timeout in clocks; 0 disables the timeout |
| per_ack_n | input | 2 | Asynchronous active-low acknowledges; bit 1 is the wide line, bit 0 the narrow line |
| per_as_n | output | 1 | Address strobe to the peripheral, active low |
| per_ds_n | output | 1 | Data strobe to the peripheral, active low |
| per_cs_n | output | 1 | Chip select to the peripheral, active low |
| xfer_done | output | 1 | Single-clock transfer acknowledge to the processor |
| xfer_err | output | 1 | Single-clock transfer error on timeout |
| port_size | output | 2 | Latched port-size code (00 none, 01 8-bit, 10 16-bit, 11 32-bit) |

## Verification
The assertions assume that the start pulse is one clock wide and that the processor changes the timeout limit only while no cycle is in progress. They also assume the peripheral keeps its acknowledges low until it sees the strobes released. The stimulus follows all three rules. Acknowledges are driven only while the data strobe is low and are held until after the done or error pulse. Starts issued during recovery are deliberate single-cycle pulses, and the limit is written only between transfers.

// File: rtl/hab_pkg.sv
// Package for the handshake bridge: sequencer state encoding and
// fixed line counts shared by the bridge modules.
package hab_pkg;

    // Number of asynchronous acknowledge lines from the peripheral.
    localparam int ACK_LINES = 2;

    // Sequencer states: idle, address phase, data phase (waiting for
    // an answer), and recovery (waiting for acknowledges to clear).
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ADDR    = 2'd1,
        ST_DATA    = 2'd2,
        ST_RECOVER = 2'd3
    } hab_state_e;

endpackage

// File: rtl/hab_sync.sv
// Multi-stage flop synchronizer for a bus of independent single-bit
// signals that have no clock relation to clk.
// Assumes each bit is a level that is held long enough to be seen; no
// coherence between bits is promised. Reset loads RST_VAL into every stage.
module hab_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage: capture the asynchronous level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= {W{RST_VAL}};
                else        chain[s] <= d;
            end
        end else begin : g_rest
            // Later stages: let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= {W{RST_VAL}};
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/hab_timer.sv
// Wait-state timeout counter. Counts clocks while run is high and
// flags expiry on the clock whose edge completes the limit-th count.
// Assumes limit is stable while run is high; a limit of 0 disables it.
module hab_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);

    logic [TMO_W-1:0] cnt;
    logic             enabled;

    assign enabled = (limit != '0);

    // Count cycles in the data phase; clear whenever not running.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (!expire) cnt <= cnt + 1'b1;
    end

    // Expiry is seen on the last allowed wait cycle.
    assign expire = run && enabled && (cnt == limit - 1'b1);

    a_r8_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (run && enabled) |-> (cnt < limit))
        else $error("R8: wait counter passed the limit");

    a_r9_no_expire_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |-> !expire)
        else $error("R9: expiry with timeout disabled");

endmodule

// File: rtl/hab_seq.sv
// Strobe sequencer. Runs one peripheral cycle per accepted start:
// address strobe and chip select first, then the data strobe. It ends the
// cycle on a synchronized acknowledge (done) or on timer expiry (error),
// then holds off new starts until both acknowledges are clear.
// Assumes ack_seen is already synchronous and active high; all outputs
// are registered so the strobes cannot glitch.
module hab_seq
    import hab_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 sel,
    input  logic [ACK_LINES-1:0] ack_seen,
    input  logic                 expire,
    output logic                 run,
    output logic                 as_n,
    output logic                 ds_n,
    output logic                 cs_n,
    output logic                 done,
    output logic                 err,
    output logic [ACK_LINES-1:0] size
);

    hab_state_e state, nxt;
    logic       any_ack;
    logic       end_ok;
    logic       end_tmo;

    assign any_ack = |ack_seen;
    assign end_ok  = (state == ST_DATA) && any_ack;
    assign end_tmo = (state == ST_DATA) && !any_ack && expire;
    assign run     = (state == ST_DATA);

    // Next-state choice for the cycle sequence.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start && sel)       nxt = ST_ADDR;
            ST_ADDR:                            nxt = ST_DATA;
            ST_DATA:    if (end_ok || end_tmo)  nxt = ST_RECOVER;
            ST_RECOVER: if (!any_ack)           nxt = ST_IDLE;
            default:                            nxt = ST_IDLE;
        endcase
    end

    // State register and strobes registered from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            as_n  <= 1'b1;
            cs_n  <= 1'b1;
            ds_n  <= 1'b1;
        end else begin
            state <= nxt;
            as_n  <= !((nxt == ST_ADDR) || (nxt == ST_DATA));
            cs_n  <= !((nxt == ST_ADDR) || (nxt == ST_DATA));
            ds_n  <= !(nxt == ST_DATA);
        end
    end

    // End-of-cycle pulses and the latched port-size code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
            size <= '0;
        end else begin
            done <= end_ok;
            err  <= end_tmo;
            if (end_ok)       size <= ack_seen;
            else if (end_tmo) size <= '0;
        end
    end

    a_r5_done_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("R5: done longer than one clock");

    a_r5_err_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err)
        else $error("R5: error longer than one clock");

    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err))
        else $error("R5: done and error together");

    a_r5_strobes_released: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> (as_n && ds_n && cs_n))
        else $error("R5: strobe still low at cycle end");

    a_r2_data_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ds_n) |-> (!as_n && !cs_n && $past(!as_n)))
        else $error("R2: data strobe without prior address phase");

    a_r8_err_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(run))
        else $error("R8: error outside data phase");

    a_r7_hold_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RECOVER) && any_ack) |=> as_n)
        else $error("R7: new cycle before acknowledges cleared");

endmodule

// File: rtl/hs_ack_bridge.sv
// Top of the handshake bridge. Synchronizes the two active-low
// peripheral acknowledges, runs the strobe sequencer and the wait-state
// timer, and presents a one-clock done or error to the processor.
// Assumes: one-clock start pulses, wait_limit changed only between
// cycles, and acknowledges held low until the strobes are released.
module hs_ack_bridge
    import hab_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TMO_W       = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xfer_start,
    input  logic                 xfer_sel,
    input  logic [TMO_W-1:0]     wait_limit,
    input  logic [ACK_LINES-1:0] per_ack_n,
    output logic                 per_as_n,
    output logic                 per_ds_n,
    output logic                 per_cs_n,
    output logic                 xfer_done,
    output logic                 xfer_err,
    output logic [ACK_LINES-1:0] port_size
);

    logic [ACK_LINES-1:0] ack_sync_n;
    logic [ACK_LINES-1:0] ack_seen;
    logic                 tmr_run;
    logic                 tmr_expire;

    hab_sync #(
        .W       (ACK_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (per_ack_n),
        .q     (ack_sync_n)
    );

    assign ack_seen = ~ack_sync_n;

    hab_timer #(
        .TMO_W (TMO_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .limit  (wait_limit),
        .expire (tmr_expire)
    );

    hab_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (xfer_start),
        .sel      (xfer_sel),
        .ack_seen (ack_seen),
        .expire   (tmr_expire),
        .run      (tmr_run),
        .as_n     (per_as_n),
        .ds_n     (per_ds_n),
        .cs_n     (per_cs_n),
        .done     (xfer_done),
        .err      (xfer_err),
        .size     (port_size)
    );

    a_r4_done_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> $past(ack_seen != '0))
        else $error("R4: done without a synchronized acknowledge");

    a_r6_size_matches_done: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (port_size != '0))
        else $error("R6: done with empty size code");

endmodule

// File: tb/hs_ack_bridge_test.sv
`timescale 1ns/1ps
module hs_ack_bridge_test;

    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xfer_start = 1'b0;
    logic          xfer_sel = 1'b0;
    logic [TW-1:0] wait_limit = 8'd8;
    logic [1:0]    per_ack_n = 2'b11;
    logic          per_as_n, per_ds_n, per_cs_n;
    logic          xfer_done, xfer_err;
    logic [1:0]    port_size;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;
    bit finished = 1'b0;

    typedef struct {
        bit       is_err;
        bit [1:0] size;
        int       at;
        string    req;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hs_ack_bridge #(.SYNC_STAGES(2), .TMO_W(TW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .xfer_sel   (xfer_sel),
        .wait_limit (wait_limit),
        .per_ack_n  (per_ack_n),
        .per_as_n   (per_as_n),
        .per_ds_n   (per_ds_n),
        .per_cs_n   (per_cs_n),
        .xfer_done  (xfer_done),
        .xfer_err   (xfer_err),
        .port_size  (port_size)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops an expected ending whenever done or error appears.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (xfer_done || xfer_err)) begin
                if (sb.size() == 0) begin
                    nchk++; nfail++;
                    $display("FAIL R5: unexpected pulse done=%0b err=%0b, actual 1 expected 0",
                             xfer_done, xfer_err);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.req, " kind"},  {31'd0, xfer_err}, {31'd0, e.is_err});
                    chk({e.req, " cycle"}, cyc, e.at);
                    chk({e.req, " R6 size"}, {30'd0, port_size}, {30'd0, e.size});
                    chk("R5 strobes released", {per_as_n, per_ds_n, per_cs_n}, 3'b111);
                end
            end
        end
    end

    // Driver: one transfer. code = acknowledge lines to pull (0 = none),
    // dly = negedges in the data phase before answering.
    task automatic xfer(input bit [1:0] code, input int dly, input string req);
        int c;
        @(negedge clk);
        xfer_start = 1'b1; xfer_sel = 1'b1;
        c = cyc;
        @(negedge clk);
        xfer_start = 1'b0; xfer_sel = 1'b0;
        chk("R2 addr phase", {per_as_n, per_cs_n, per_ds_n}, 3'b001);
        @(negedge clk);
        chk("R2 data phase", {per_as_n, per_cs_n, per_ds_n}, 3'b000);
        if (code == 2'b00) begin
            sb.push_back('{1'b1, 2'b00, c + 2 + int'(wait_limit), req});
            repeat (int'(wait_limit) + 2) @(negedge clk);
        end else begin
            repeat (dly) @(negedge clk);
            per_ack_n = ~code;
            if (wait_limit != 0 && (cyc + 3) > (c + 2 + int'(wait_limit)))
                sb.push_back('{1'b1, 2'b00, c + 2 + int'(wait_limit), req});
            else
                sb.push_back('{1'b0, code, cyc + 3, req});
            repeat (5) @(negedge clk);
            per_ack_n = 2'b11;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 strobes", {per_as_n, per_ds_n, per_cs_n}, 3'b111);
        chk("R1 pulses", {xfer_done, xfer_err}, 2'b00);
        chk("R1 size", {30'd0, port_size}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: start without select
        xfer_start = 1'b1; xfer_sel = 1'b0;
        @(negedge clk);
        xfer_start = 1'b0;
        chk("R3 no select", {per_as_n, per_ds_n, per_cs_n}, 3'b111);
        @(negedge clk);
        chk("R3 no select later", {per_as_n, per_ds_n, per_cs_n}, 3'b111);

        // R4/R6: three size codes, different latencies
        xfer(2'b01, 0, "R4 narrow");
        xfer(2'b10, 2, "R4 wide");
        xfer(2'b11, 1, "R6 both");

        // R8: timeout with limit 5
        wait_limit = 8'd5;
        xfer(2'b00, 0, "R8 timeout");
        // R10: acknowledge seen on the expiry edge (dly = N-3)
        xfer(2'b11, 2, "R10 tie");
        // R9: timeout disabled, long wait
        wait_limit = 8'd0;
        xfer(2'b10, 20, "R9 disabled");
        wait_limit = 8'd8;

        // R7: starts during recovery
        begin
            int q;
            @(negedge clk);
            xfer_start = 1'b1; xfer_sel = 1'b1;
            @(negedge clk);
            xfer_start = 1'b0; xfer_sel = 1'b0;
            @(negedge clk);
            per_ack_n = 2'b00;
            sb.push_back('{1'b0, 2'b11, cyc + 3, "R7 setup"});
            repeat (4) @(negedge clk);
            xfer_start = 1'b1; xfer_sel = 1'b1;
            @(negedge clk);
            xfer_start = 1'b0; xfer_sel = 1'b0;
            chk("R7 start while held", {31'd0, per_as_n}, 32'd1);
            per_ack_n = 2'b11;
            q = cyc;
            repeat (2) @(negedge clk);
            xfer_start = 1'b1; xfer_sel = 1'b1;
            @(negedge clk);
            xfer_start = 1'b0; xfer_sel = 1'b0;
            chk("R7 start at third edge", {31'd0, per_as_n}, 32'd1);
            chk("R7 cycle count", cyc, q + 3);
            xfer_start = 1'b1; xfer_sel = 1'b1;
            @(negedge clk);
            xfer_start = 1'b0; xfer_sel = 1'b0;
            chk("R7 start at fourth edge", {31'd0, per_as_n}, 32'd0);
            @(negedge clk);
            per_ack_n = 2'b10;
            sb.push_back('{1'b0, 2'b01, cyc + 3, "R7 follow-up"});
            repeat (5) @(negedge clk);
            per_ack_n = 2'b11;
            repeat (4) @(negedge clk);
        end

        chk("R5 all endings seen", sb.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule